// File: doc/BRIEF.md
# Timed-Window Critical Register Guard

This block keeps a small bank of critical configuration registers behind a lock that is set once initialization ends. While the lock is set, every write to the bank is thrown away and a sticky violation flag is raised. Software can reopen the bank only by presenting a 32-bit key word. The word must carry the right password and a fixed guard pattern. A correct key opens a write window of a fixed number of clock cycles. When that count runs out, the lock closes again by itself.

The same key word, with its request bit set, closes the window at once. A key with a wrong password or wrong guard bits changes nothing and raises a one-cycle alarm. A window that runs out raises a separate one-cycle alarm. After reset the bank starts in an open window of the same length, so boot code can load the registers before the lock closes for the first time. Reads are always allowed and return data one cycle after the read address is presented.

Top module: `crit_reg_guard`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `locked` is 0, `violation` is 0 and both alarm outputs are 0.
- R2: After reset, the lock stays open for exactly WINDOW clock edges. On the WINDOW-th edge `locked` goes to 1, and `alarm_timeout` is 1 for that one cycle only.
- R3: A key word is valid only when bits 31:16 equal PASSWORD and bits 15:14 equal 2'b01. Bit 0 is the requested lock state, and bits 13:1 are ignored.
- R4: A valid key with bit 0 = 0 clears `locked` on the next edge and reloads the window to WINDOW cycles. This applies even if the window is already open. The lock then closes again after WINDOW further edges, with an `alarm_timeout` pulse.
- R5: A valid key with bit 0 = 1 sets `locked` on the next edge and stops the window, without an `alarm_timeout` pulse.
- R6: An invalid key leaves `locked` unchanged and drives `alarm_badkey` high for one cycle after the write.
- R7: A register write presented while `locked` is 1 does not change the bank. It sets `violation`, which stays 1 until reset.
- R8: A register write presented while `locked` is 0 is stored. This includes the last cycle of a window. The lock state before the clock edge decides whether a write is accepted.
- R9: `reg_rdata` shows the content at `reg_raddr` one cycle after the address is presented, whatever the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unlock_we | input | 1 | Key word write strobe |
| unlock_word | input | 32 | Key word: password, guard bits, lock request |
| reg_we | input | 1 | Register bank write strobe |
| reg_waddr | input | AW | Register write index |
| reg_wdata | input | DW | Register write data |
| reg_raddr | input | AW | Register read index |
| reg_rdata | output | DW | Registered read data |
| locked | output | 1 | 1 while the bank is write protected |
| alarm_badkey | output | 1 | One-cycle pulse after a rejected key |
| alarm_timeout | output | 1 | One-cycle pulse when a window expires |
| violation | output | 1 | Sticky flag for a write refused by the lock |

## Verification
The bench builds the block with WINDOW = 16, eight 16-bit registers and password 16'hA5C3. The short window lets the bench count every cycle of the reset window and of a reloaded window. That reaches the exact expiry edge, and it allows a write on the final open cycle followed by a refused write on the next one. Eight registers are enough to fill the bank during the first window. They are also enough to read back both accepted and refused writes, and to reject keys with each wrong guard pattern.

// File: rtl/crg_pkg.sv
package crg_pkg;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_OPEN   = 2'd1,
    CMD_CLOSE  = 2'd2,
    CMD_REJECT = 2'd3
  } crg_cmd_e;

  localparam logic [1:0] GUARD_OK = 2'b01;

endpackage

// File: rtl/crg_key_check.sv
module crg_key_check
  import crg_pkg::*;
#(
  parameter logic [15:0] PASSWORD = 16'hA5C3
) (
  input  logic        wr,
  input  logic [31:0] word,
  output crg_cmd_e    cmd
);

  logic        pw_hit;
  logic        guard_hit;
  logic        unused_spare;

  assign pw_hit       = (word[31:16] == PASSWORD);
  assign guard_hit    = (word[15:14] == GUARD_OK);
  assign unused_spare = ^word[13:1];

  always_comb begin
    cmd = CMD_NONE;
    if (wr) begin
      if (pw_hit && guard_hit) cmd = word[0] ? CMD_CLOSE : CMD_OPEN;
      else                     cmd = CMD_REJECT;
    end
  end

endmodule

// File: rtl/crg_window_timer.sv
module crg_window_timer
  import crg_pkg::*;
#(
  parameter int WINDOW = 256
) (
  input  logic     clk,
  input  logic     rst,
  input  crg_cmd_e cmd,
  output logic     locked,
  output logic     expired
);

  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked  <= 1'b0;
      remain  <= CW'(WINDOW);
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      case (cmd)
        CMD_OPEN: begin
          locked <= 1'b0;
          remain <= CW'(WINDOW);
        end
        CMD_CLOSE: begin
          locked <= 1'b1;
          remain <= '0;
        end
        default: begin
          if (!locked) begin
            if (remain == CW'(1)) begin
              locked  <= 1'b1;
              remain  <= '0;
              expired <= 1'b1;
            end else begin
              remain <= remain - CW'(1);
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/crg_reg_bank.sv
module crg_reg_bank #(
  parameter int NREGS = 8,
  parameter int DW    = 32,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/crit_reg_guard.sv
module crit_reg_guard
  import crg_pkg::*;
#(
  parameter logic [15:0] PASSWORD = 16'hA5C3,
  parameter int          WINDOW   = 256,
  parameter int          NREGS    = 8,
  parameter int          DW       = 32,
  localparam int         AW       = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          unlock_we,
  input  logic [31:0]   unlock_word,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_waddr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [AW-1:0] reg_raddr,
  output logic [DW-1:0] reg_rdata,
  output logic          locked,
  output logic          alarm_badkey,
  output logic          alarm_timeout,
  output logic          violation
);

  crg_cmd_e cmd;
  logic     bank_we;

  crg_key_check #(.PASSWORD(PASSWORD)) u_key (
    .wr   (unlock_we),
    .word (unlock_word),
    .cmd  (cmd)
  );

  crg_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .locked  (locked),
    .expired (alarm_timeout)
  );

  assign bank_we = reg_we && !locked;

  crg_reg_bank #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_bank (
    .clk   (clk),
    .we    (bank_we),
    .waddr (reg_waddr),
    .wdata (reg_wdata),
    .raddr (reg_raddr),
    .rdata (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_badkey <= 1'b0;
      violation    <= 1'b0;
    end else begin
      alarm_badkey <= (cmd == CMD_REJECT);
      if (reg_we && locked) violation <= 1'b1;
    end
  end

endmodule

// File: rtl/crg_checker.sv
module crg_checker #(
  parameter logic [15:0] PASSWORD = 16'hA5C3
) (
  input logic        clk,
  input logic        rst,
  input logic        unlock_we,
  input logic [31:0] unlock_word,
  input logic        reg_we,
  input logic        locked,
  input logic        alarm_badkey,
  input logic        alarm_timeout,
  input logic        violation
);

  logic key_ok;
  assign key_ok = unlock_we && (unlock_word[31:16] == PASSWORD) &&
                  (unlock_word[15:14] == 2'b01);

  assert_expire_edge_R2: assert property (@(posedge clk) disable iff (rst)
    alarm_timeout |-> (locked && $past(!locked)));

  assert_open_R4: assert property (@(posedge clk) disable iff (rst)
    (key_ok && !unlock_word[0]) |=> (!locked && !alarm_badkey));

  assert_close_R5: assert property (@(posedge clk) disable iff (rst)
    (key_ok && unlock_word[0]) |=> (locked && !alarm_timeout));

  assert_bad_guard_R6: assert property (@(posedge clk) disable iff (rst)
    (unlock_we && unlock_word[15:14] != 2'b01) |=> alarm_badkey);

  assert_stay_locked_R6: assert property (@(posedge clk) disable iff (rst)
    (unlock_we && !key_ok && locked) |=> locked);

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_we && locked) |=> violation);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);

endmodule

bind crit_reg_guard crg_checker #(.PASSWORD(PASSWORD)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .unlock_we     (unlock_we),
  .unlock_word   (unlock_word),
  .reg_we        (reg_we),
  .locked        (locked),
  .alarm_badkey  (alarm_badkey),
  .alarm_timeout (alarm_timeout),
  .violation     (violation)
);

// File: tb/crit_reg_guard_test.sv
`timescale 1ns/1ps
module crit_reg_guard_test;

  localparam logic [15:0] PW  = 16'hA5C3;
  localparam int          WIN = 16;
  localparam int          NR  = 8;
  localparam int          DW  = 16;
  localparam int          AW  = 3;
  localparam int          NV  = 12;

  // kind[56:55] 0 idle 1 key 2 write | word[54:23] | addr[22:20] | data[19:4]
  // expected after edge: locked[3] badkey[2] timeout[1] violation[0]
  localparam logic [56:0] VEC [NV] = '{
    {2'd2, 32'h0000_0000, 3'd1, 16'h1111, 4'b1001}, // R7 write refused
    {2'd1, 32'h1234_4000, 3'd0, 16'h0000, 4'b1101}, // R6 wrong password
    {2'd1, 32'hA5C3_8000, 3'd0, 16'h0000, 4'b1101}, // R3 guard 10
    {2'd1, 32'hA5C3_C000, 3'd0, 16'h0000, 4'b1101}, // R3 guard 11
    {2'd1, 32'hA5C3_0000, 3'd0, 16'h0000, 4'b1101}, // R3 guard 00
    {2'd1, 32'hA5C3_4000, 3'd0, 16'h0000, 4'b0001}, // R4 valid open
    {2'd2, 32'h0000_0000, 3'd1, 16'h2222, 4'b0001}, // R8 write accepted
    {2'd1, 32'hA5C3_8000, 3'd0, 16'h0000, 4'b0101}, // R6 bad key while open
    {2'd1, 32'hA5C3_4001, 3'd0, 16'h0000, 4'b1001}, // R5 close now
    {2'd2, 32'h0000_0000, 3'd2, 16'h3333, 4'b1001}, // R7 refused
    {2'd1, 32'hA5C3_7FFE, 3'd0, 16'h0000, 4'b0001}, // R3 spare bits ignored
    {2'd1, 32'hA5C3_4003, 3'd0, 16'h0000, 4'b1001}  // R5 close, spare bits
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          unlock_we = 1'b0;
  logic [31:0]   unlock_word = '0;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_waddr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_raddr = '0;
  logic [DW-1:0] reg_rdata;
  logic          locked, alarm_badkey, alarm_timeout, violation;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  crit_reg_guard #(.PASSWORD(PW), .WINDOW(WIN), .NREGS(NR), .DW(DW)) uut (
    .clk(clk), .rst(rst), .unlock_we(unlock_we), .unlock_word(unlock_word),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .locked(locked),
    .alarm_badkey(alarm_badkey), .alarm_timeout(alarm_timeout),
    .violation(violation)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_in();
    unlock_we = 1'b0;
    reg_we    = 1'b0;
  endtask

  task automatic flags(input string req, input logic [3:0] e);
    chk(req, {28'd0, locked, alarm_badkey, alarm_timeout, violation}, {28'd0, e});
  endtask

  task automatic rd(input string req, input int a, input logic [DW-1:0] e);
    idle_in();
    reg_raddr = AW'(a);
    step();
    chk(req, {16'd0, reg_rdata}, {16'd0, e});
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    flags("R1 in reset", 4'b0000);
    rst = 1'b0;
    step();
    flags("R1 first cycle", 4'b0000);

    // R2/R8: initial window, fill bank in first NR cycles (edges 2..9)
    for (int k = 2; k <= WIN; k++) begin
      if (k - 2 < NR) begin
        reg_we = 1'b1; reg_waddr = AW'(k - 2); reg_wdata = 16'hC000 | 16'(k - 2);
      end else begin
        reg_we = 1'b0;
      end
      step();
      if (k < WIN) chk("R2 still open", {31'd0, locked}, 32'd0);
      else         flags("R2 expiry edge", 4'b1010);
    end
    idle_in();
    step();
    flags("R2 alarm single cycle", 4'b1000);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      v = VEC[i];
      unlock_we   = (v[56:55] == 2'd1);
      unlock_word = v[54:23];
      reg_we      = (v[56:55] == 2'd2);
      reg_waddr   = v[22:20];
      reg_wdata   = v[19:4];
      step();
      flags($sformatf("R3-R8 vector %0d", i), v[3:0]);
    end
    idle_in();

    rd("R8 stored in window", 1, 16'h2222);
    rd("R7 refused write", 2, 16'hC002);
    rd("R9 read while locked", 0, 16'hC000);
    rd("R9 read last", 7, 16'hC007);

    // R4: reload while open, then last-cycle write accepted
    unlock_we = 1'b1; unlock_word = {PW, 16'h4000};
    step();
    idle_in();
    repeat (WIN - 2) step();
    chk("R4 open before reload", {31'd0, locked}, 32'd0);
    unlock_we = 1'b1; unlock_word = {PW, 16'h4000};
    step();
    idle_in();
    for (int k = 1; k <= WIN; k++) begin
      if (k == WIN) begin
        reg_we = 1'b1; reg_waddr = 3'd3; reg_wdata = 16'hBEEF;
      end
      step();
      if (k < WIN) chk("R4 reloaded window open", {31'd0, locked}, 32'd0);
      else         flags("R4 reloaded window expiry", 4'b1011);
    end
    reg_we = 1'b1; reg_waddr = 3'd4; reg_wdata = 16'hDEAD;
    step();
    flags("R7 refused after expiry", 4'b1001);
    rd("R8 last open cycle stored", 3, 16'hBEEF);
    rd("R7 post-expiry discarded", 4, 16'hC004);

    // R1: reset again clears sticky flag and reopens
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    flags("R1 reset after run", 4'b0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule